// File: doc/BRIEF.md
# Serial Configuration Slave with Output-Pair Enables

This block is the configuration port of a multi-output clock buffer. It watches a two-wire serial bus (SCL and SDA), oversampled by a much faster system clock. It answers one device address in two forms: 0xD4 for writes and 0xD5 for reads. It keeps seven 8-bit configuration registers, and a handful of their bits drive the enable lines of the clock output pairs.

A write is a block transfer. After the address come two bytes that are acknowledged and discarded: a command byte and a length byte. Every later byte fills the next register, starting at register 0 and counting up. The host may stop after any whole byte. A read returns a length byte of 7 and then the seven registers in ascending order. The host acknowledges each byte, and a NACK ends the data phase.

Control is a single state machine with these states: IDLE (bus free), ADDR (shifting in the address), ADDR_ACK (acknowledging the address), WR_BYTE (shifting in a write byte), WR_ACK (acknowledging a write byte), RD_BYTE (shifting out a read byte), RD_ACK (sampling the host acknowledge) and IGNORE (not addressed, or read ended). The transitions are:
- A STOP leads to IDLE from any state.
- A START leads to ADDR from any state.
- From ADDR, the eighth SCL fall leads to ADDR_ACK on an address match, or to IGNORE otherwise.
- From ADDR_ACK, the SCL fall leads to WR_BYTE or RD_BYTE, depending on the direction bit.
- WR_BYTE leads to WR_ACK on the eighth SCL fall, and WR_ACK returns to WR_BYTE on the next fall.
- RD_BYTE leads to RD_ACK on the eighth SCL fall.
- RD_ACK leads to RD_BYTE when the host acknowledged, or to IGNORE when it did not.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset all seven registers hold 0xFF, all six pair enables are 1, and a read returns 0xFF for every register.
- R2: Only the address bytes 0xD4 (write) and 0xD5 (read) are acknowledged. After any other address the block neither acknowledges nor stores anything until the next START or STOP.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. Each later byte is acknowledged and stored, in order, into register 0, 1, 2 and so on.
- R4: A STOP after any complete byte ends the write. Registers already written keep their new values, and the remaining registers keep their old values.
- R5: Write data bytes after register 6 are acknowledged and change no register.
- R6: A read first returns a length byte of value 7, then registers 0 to 6, each sent MSB first. Any byte requested after register 6 reads as 0xFF.
- R7: A NACK from the host after a read byte ends the data phase. SDA stays released (reads as 1) until the next START.
- R8: Each pair enable is 1 for enabled and 0 for disabled. Pair 0 follows register 5 bit 7, pair 2 follows register 5 bit 3, pair 3 follows register 5 bit 2, pair 4 follows register 6 bit 3, and pair 5 follows register 6 bit 1. Pair 1 has no control bit and stays 1.
- R9: A START in the middle of a transfer, even in the middle of a byte, restarts the address phase.
- R10: The block pulls SDA low for the acknowledge clock, and changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| pair_en | output | 6 | Enable per output pair, 1 = enabled |

## Verification
A state machine stuck in the wrong state shows at the next acknowledge slot, less than one byte time later: SDA is high where a low acknowledge is expected, or low where the host expects a released line. A byte or write index that is off by one shows on the following readback, as a shifted register value or a missing length byte. A wrong enable mapping shows on pair_en within one system clock of the write that causes it.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    // Bus-side control states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

    localparam int PAIRS = 6;

endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SDA moving while SCL stays high marks a bus condition
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile #(
    parameter int         NUM_REGS  = 7,
    parameter int         IDX_W     = 4,
    parameter logic [7:0] RESET_VAL = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata,
    output logic [5:0]       pair_en
);

    localparam int EN_REG_LO = 5;
    localparam int EN_REG_HI = 6;

    logic [7:0] regs [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[g] <= RESET_VAL;
                end else if (we && (waddr == IDX_W'(g))) begin
                    regs[g] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = RESET_VAL;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == IDX_W'(i)) begin
                rdata = regs[i];
            end
        end
    end

    // Scattered enable bits, 1 = pair enabled
    assign pair_en[0] = regs[EN_REG_LO][7];
    assign pair_en[1] = 1'b1;
    assign pair_en[2] = regs[EN_REG_LO][3];
    assign pair_en[3] = regs[EN_REG_LO][2];
    assign pair_en[4] = regs[EN_REG_HI][3];
    assign pair_en[5] = regs[EN_REG_HI][1];

endmodule

// File: rtl/cfgs_bus_fsm.sv
module cfgs_bus_fsm
    import cfgs_pkg::*;
#(
    parameter int         NUM_REGS = 7,
    parameter int         IDX_W    = 4,
    parameter logic [6:0] DEV_ADDR = 7'h6A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       reg_rdata,
    output logic [IDX_W-1:0] reg_raddr,
    output logic             reg_we,
    output logic [IDX_W-1:0] reg_waddr,
    output logic [7:0]       reg_wdata,
    output logic             sda_drive_low,
    output bus_state_e       state
);

    localparam logic [7:0]       ADDR_WR  = {DEV_ADDR, 1'b0};
    localparam logic [7:0]       ADDR_RD  = {DEV_ADDR, 1'b1};
    localparam logic [IDX_W-1:0] WR_FIRST = IDX_W'(2);
    localparam logic [IDX_W-1:0] WR_LAST  = IDX_W'(NUM_REGS + 2);
    localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(NUM_REGS + 1);
    localparam logic [3:0]       BYTE_END = 4'd8;

    bus_state_e       state_q, state_d;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [7:0]       tx_next;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             is_read;
    logic             host_ack;
    logic             byte_done;

    assign byte_done = scl_fall && (bit_cnt == BYTE_END);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR: begin
                    if (byte_done) begin
                        state_d = ((rx_sh == ADDR_WR) || (rx_sh == ADDR_RD))
                                  ? ST_ADDR_ACK : ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) state_d = is_read ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && (bit_cnt == 4'd7)) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = host_ack ? ST_RD_BYTE : ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
            endcase
        end
    end

    // Read byte selection: length byte, then registers, then all-ones
    assign reg_raddr = rd_idx - IDX_W'(1);

    always_comb begin
        if (rd_idx == '0) begin
            tx_next = 8'(NUM_REGS);
        end else if (rd_idx <= IDX_W'(NUM_REGS)) begin
            tx_next = reg_rdata;
        end else begin
            tx_next = 8'hFF;
        end
    end

    // Byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= 8'hFF;
            wr_idx   <= '0;
            rd_idx   <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
        end else if (stop_det) begin
            tx_sh <= 8'hFF;
        end else if (start_det) begin
            bit_cnt <= '0;
            wr_idx  <= '0;
            rd_idx  <= '0;
            tx_sh   <= 8'hFF;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && (bit_cnt != BYTE_END)) begin
                        rx_sh   <= {rx_sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done && (state_q == ST_ADDR)) begin
                        is_read <= (rx_sh == ADDR_RD);
                    end
                    if (byte_done && (state_q == ST_WR_BYTE) && (wr_idx != WR_LAST)) begin
                        wr_idx <= wr_idx + IDX_W'(1);
                    end
                end
                ST_ADDR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if ((state_q == ST_ADDR_ACK) && is_read) begin
                            tx_sh  <= tx_next;
                            rd_idx <= rd_idx + IDX_W'(1);
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        tx_sh   <= {tx_sh[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (host_ack) begin
                            tx_sh <= tx_next;
                            if (rd_idx != RD_LAST) rd_idx <= rd_idx + IDX_W'(1);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Register write strobe at the end of a stored data byte
    always_comb begin
        reg_we    = (state_q == ST_WR_BYTE) && byte_done && !start_det && !stop_det
                    && (wr_idx >= WR_FIRST) && (wr_idx < WR_LAST);
        reg_waddr = wr_idx - WR_FIRST;
        reg_wdata = rx_sh;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_drive_low = 1'b1;
            ST_RD_BYTE:             sda_drive_low = ~tx_sh[7];
            default:                sda_drive_low = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgs_pkg::*;
#(
    parameter int         NUM_REGS    = 7,
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter logic [7:0] RESET_VAL   = 8'hFF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_drive_low,
    output logic [PAIRS-1:0] pair_en
);

    localparam int IDX_W = $clog2(NUM_REGS + 3);

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             reg_we;
    logic [IDX_W-1:0] reg_waddr;
    logic [7:0]       reg_wdata;
    logic [IDX_W-1:0] reg_raddr;
    logic [7:0]       reg_rdata;
    bus_state_e       state;

    cfgs_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgs_bus_fsm #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_s         (sda_s),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .reg_rdata     (reg_rdata),
        .reg_raddr     (reg_raddr),
        .reg_we        (reg_we),
        .reg_waddr     (reg_waddr),
        .reg_wdata     (reg_wdata),
        .sda_drive_low (sda_drive_low),
        .state         (state)
    );

    cfgs_regfile #(
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W),
        .RESET_VAL (RESET_VAL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .raddr   (reg_raddr),
        .rdata   (reg_rdata),
        .pair_en (pair_en)
    );

endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker
    import cfgs_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int IDX_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_drive_low,
    input logic [PAIRS-1:0] pair_en,
    input logic             reg_we,
    input logic [IDX_W-1:0] reg_waddr,
    input bus_state_e       st
);

    // R10: SDA drive moves only while SCL is low
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_in);

    // R8: enables move only after a register write
    p_en_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pair_en) |-> $past(reg_we));

    // R5: no write lands outside the register range
    p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_waddr < IDX_W'(NUM_REGS)));

    // R3: a register is stored only at the end of a byte, with SCL low
    p_store_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !scl_in);

    // R2: a non-addressed or ended transfer never drives SDA
    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE || st == ST_IDLE) |-> !sda_drive_low);

endmodule

bind cfg_serial_slave cfgs_checker #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .pair_en       (pair_en),
    .reg_we        (reg_we),
    .reg_waddr     (reg_waddr),
    .st            (state)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       sda_drive_low;
    logic [5:0] pair_en;
    logic       sda_line;
    int         nchk = 0;
    int         nfail = 0;
    logic [7:0] mdl [7];
    logic [7:0] wbuf [12];

    always #10 clk = ~clk;

    assign sda_line = host_sda & ~sda_drive_low;

    cfg_serial_slave uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (host_scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .pair_en       (pair_en)
    );

    // {reg5, reg6, expected pair_en} per R8
    localparam logic [21:0] VEC [5] = '{
        {8'h00, 8'h00, 6'h02},
        {8'h80, 8'h00, 6'h03},
        {8'h0C, 8'h0A, 6'h3E},
        {8'h7B, 8'hF5, 6'h06},
        {8'h84, 8'h08, 6'h1B}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] en_of(input logic [7:0] r5, input logic [7:0] r6);
        return {r6[1], r6[3], r5[2], r5[3], 1'b1, r5[7]};
    endfunction

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; hq();
        host_scl = 1'b1; hq();
        host_sda = 1'b0; hq();
        host_scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; hq();
        host_scl = 1'b1; hq();
        host_sda = 1'b1; hq();
        hq();
    endtask

    task automatic put_bit(input logic b);
        host_sda = b; hq();
        host_scl = 1'b1; hq();
        hq();
        host_scl = 1'b0; hq();
    endtask

    task automatic get_bit(output logic b);
        host_sda = 1'b1; hq();
        host_scl = 1'b1; hq();
        b = sda_line; hq();
        host_scl = 1'b0; hq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    // Block write of n data bytes from wbuf; model follows R3, R5
    task automatic write_regs(input int n, input string req);
        logic a;
        logic all_ack;
        bus_start();
        send_byte(8'hD4, a);
        chk("R10 address ack", a, 1);
        all_ack = 1'b1;
        send_byte(8'h3C, a); all_ack &= a;
        send_byte(8'h99, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            all_ack &= a;
            if (i < 7) mdl[i] = wbuf[i];
        end
        bus_stop();
        chk(req, all_ack, 1);
    endtask

    // Read length byte plus n bytes, checking against model per R6
    task automatic read_check(input int n, input string req);
        logic       a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD5, a);
        chk("R2 read address ack", a, 1);
        recv_byte(d, 1'b1);
        chk("R6 length byte", d, 8'd7);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i != n - 1);
            chk(req, d, (i < 7) ? mdl[i] : 8'hFF);
        end
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic       a;
        logic [7:0] d;
        logic [5:0] en_before;

        for (int i = 0; i < 7; i++) mdl[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hq();

        // R1: reset state
        chk("R1 pair_en at reset", pair_en, 6'h3F);
        chk("R1 SDA released at reset", sda_drive_low, 0);
        read_check(7, "R1 register reset value");

        // Table walk: R3 fill order, R8 enable map, R6 readback
        for (int v = 0; v < 5; v++) begin
            for (int k = 0; k < 5; k++) wbuf[k] = 8'(v * 17 + k * 3 + 1);
            wbuf[5] = VEC[v][21:14];
            wbuf[6] = VEC[v][13:6];
            write_regs(7, "R3 data byte acks");
            chk("R8 pair enable map", pair_en, VEC[v][5:0]);
            read_check(7, "R3 stored order");
        end

        // R4: stop after two data bytes
        wbuf[0] = 8'h11;
        wbuf[1] = 8'h22;
        write_regs(2, "R4 partial write acks");
        read_check(7, "R4 partial write contents");

        // R5: nine data bytes, the last two land nowhere
        for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'hA0 + k);
        wbuf[5] = 8'h84;
        wbuf[6] = 8'h08;
        wbuf[7] = 8'h00;
        wbuf[8] = 8'h00;
        write_regs(9, "R5 overflow bytes acked");
        chk("R5 enables after overflow", pair_en, en_of(mdl[5], mdl[6]));
        read_check(7, "R5 registers after overflow");

        // R6: byte requested after register 6
        read_check(8, "R6 past-end byte");

        // R2: foreign addresses
        en_before = pair_en;
        bus_start();
        send_byte(8'hA0, a);
        chk("R2 foreign address not acked", a, 0);
        send_byte(8'h00, a);
        chk("R2 byte after foreign address not acked", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'h54, a);
        chk("R2 near-miss address not acked", a, 0);
        bus_stop();
        chk("R2 enables unchanged", pair_en, en_before);
        read_check(7, "R2 registers unchanged");

        // R7: host NACK ends the read
        bus_start();
        send_byte(8'hD5, a);
        recv_byte(d, 1'b0);
        chk("R7 length byte before NACK", d, 8'd7);
        recv_byte(d, 1'b0);
        chk("R7 SDA released after NACK", d, 8'hFF);
        bus_stop();

        // R9: repeated START after a data byte
        bus_start();
        send_byte(8'hD4, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h5A, a);
        mdl[0] = 8'h5A;
        bus_start();
        send_byte(8'hD5, a);
        chk("R9 restart address ack", a, 1);
        recv_byte(d, 1'b1);
        chk("R9 length after restart", d, 8'd7);
        recv_byte(d, 1'b0);
        chk("R9 register 0 after restart", d, 8'h5A);
        bus_stop();

        // R9: START in the middle of a byte
        bus_start();
        send_byte(8'hD4, a);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start();
        send_byte(8'hD5, a);
        chk("R9 mid-byte restart ack", a, 1);
        recv_byte(d, 1'b0);
        chk("R9 length after mid-byte restart", d, 8'd7);
        bus_stop();
        read_check(7, "R9 registers after restarts");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule